// File: doc/BRIEF.md
# Asynchronous SRAM Bus Protocol Monitor

This block watches the control, address and data pins of an asynchronous 16-bit-wide static RAM interface. Those pins are sampled on a fast system clock, and the block checks them against the device's operating-mode rules and its minimum write-cycle timing. It drives nothing onto the bus. Every nanosecond limit is turned into a number of sample ticks at elaboration time with ceil(t_ns / SAMPLE_PERIOD_NS). With the default 4 ns sample period the limits are:

| Limit | Ticks |
|---|---|
| Write pulse | 10 |
| Data setup | 7 |
| Address setup, chip-select setup, byte-enable setup | 12 |
| Write cycle | 14 |

A write is the overlap of an active-low chip select and an active-low write strobe. The window opens on the later of the two falling edges and closes on the earlier rising edge. Pulse width, data setup, address setup, chip-select setup and byte-enable setup are all measured against that overlap window. The block checks the minimum spacing between address changes whenever a write lies inside the address period. It flags any address movement while the window is open, and it flags bus contention when the controller drives data while the memory is in its read state.

Each rule owns one sticky error bit, and a synchronous clear input resets them all. Two counters track completed operations: one counts legal writes and one counts legal reads. The block is meant to sit beside a memory controller in simulation or in silicon as a passive watchdog.

Top module: `sram_bus_monitor`

## Requirements
- R1: After reset, err_o is all zeros, and wr_count_o and rd_count_o are zero. The first sample after reset only loads history and raises no timing rule.
- R2: The write window is open in a sample when both cs_n_i and we_n_i are low. The pulse width is the number of samples in that overlap, so a strobe that falls earlier than the other strobe adds nothing to it. A strobe that is low while the other stays high opens no window, counts no write and raises no timing rule.
- R3: If a window closes after fewer than 10 open samples, err_o bit 0 is set. Exactly 10 samples is legal.
- R4: If data_i has held its value for fewer than 7 samples up to the last open sample of the window, err_o bit 1 is set. A change of data_i on the closing sample is legal, because hold is zero.
- R5: If addr_i has held its value for fewer than 12 samples up to the last open sample, err_o bit 2 is set.
- R6: If cs_n_i has been low for fewer than 12 samples up to the last open sample, err_o bit 3 is set.
- R7: If at least one of lbe_n_i/ube_n_i has been continuously low for fewer than 12 samples up to the last open sample, err_o bit 4 is set. Having neither low also sets bit 4.
- R8: When addr_i changes and a write window closed during the address period that is just ending, a period shorter than 14 samples sets err_o bit 5. Exactly 14 samples is legal.
- R9: A change of addr_i between two consecutive samples that both have the window open sets err_o bit 6.
- R10: A sample with host_drive_i high, cs_n_i low, oe_n_i low and we_n_i high sets err_o bit 7.
- R11: Error bits are sticky. A sample with clear_i high leaves err_o all zeros, even if a rule fires in that same sample.
- R12: wr_count_o increments by one on the sample where a window closes, provided none of the R3–R7 checks fails at that close and R9 did not fire while the window was open. A failed R8 check does not block the count.
- R13: rd_count_o increments on the sample where oe_n_i rises, provided that since the previous rise at least one sample had cs_n_i low, oe_n_i low, we_n_i high and at least one byte enable low, and no R10 contention occurred.
- R14: The tick limits come from ceil(t_ns / SAMPLE_PERIOD_NS): 40, 25, 45, 45, 45 and 55 ns at 4 ns give 10, 7, 12, 12, 12 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Synchronous clear of all error bits |
| cs_n_i | input | 1 | Sampled chip select, active low |
| we_n_i | input | 1 | Sampled write strobe, active low |
| oe_n_i | input | 1 | Sampled output enable, active low |
| lbe_n_i | input | 1 | Sampled low-byte enable, active low |
| ube_n_i | input | 1 | Sampled high-byte enable, active low |
| addr_i | input | ADDR_W | Sampled address pins |
| data_i | input | DATA_W | Sampled data pins |
| host_drive_i | input | 1 | Controller's data-drive enable |
| err_o | output | 8 | Sticky rule flags, bit per rule as in R3–R10 |
| wr_count_o | output | CNT_W | Count of legal writes |
| rd_count_o | output | CNT_W | Count of legal reads |

## Verification
Each run-length timer, or the address-period counter, can be off by one. That error shows up at the ports on the closing sample of a boundary-length write: the error bit for that rule moves one sample after the close, and the write counter either does or does not advance. The directed tests therefore drive each limit at its legal value and one tick below it. A lost window-open or read-activity state shows as a missing or extra count no later than the closing sample or the output-enable rise. A broken sticky or clear path shows as err_o changing during idle samples that carry no stimulus.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;

    localparam int NUM_RULES   = 8;
    localparam int RULE_PULSE  = 0;
    localparam int RULE_DSETUP = 1;
    localparam int RULE_ASETUP = 2;
    localparam int RULE_CSETUP = 3;
    localparam int RULE_BSETUP = 4;
    localparam int RULE_CYCLE  = 5;
    localparam int RULE_MOVE   = 6;
    localparam int RULE_CONT   = 7;

    // Round a nanosecond limit up to whole sample ticks.
    function automatic int ns_to_ticks(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_mon_run_timer.sv
// Tracks a sampled value and how many consecutive samples it has held.
module sram_mon_run_timer #(
    parameter int W     = 1,
    parameter int CNT_W = 4,
    parameter int SAT   = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             first_i,
    input  logic [W-1:0]     value_i,
    output logic [W-1:0]     val_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             chg_o
);
    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    typedef struct packed {
        logic [W-1:0]     val;
        logic [CNT_W-1:0] cnt;
    } run_t;

    run_t run_d, run_q;

    assign chg_o = !first_i && (value_i != run_q.val);
    assign val_o = run_q.val;
    assign cnt_o = run_q.cnt;

    always_comb begin
        run_d = run_q;
        if (first_i || chg_o) begin
            run_d.val = value_i;
            run_d.cnt = ONE_V;
        end else if (run_q.cnt < SAT_V) begin
            run_d.cnt = run_q.cnt + ONE_V;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) run_q <= '0;
        else         run_q <= run_d;
    end
endmodule

// File: rtl/sram_mon_sticky.sv
// Bank of sticky flags with a synchronous clear that takes priority.
module sram_mon_sticky #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic [N-1:0] set_i,
    output logic [N-1:0] flags_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flag_d, flag_q;
        always_comb begin
            flag_d = flag_q | set_i[g];
            if (clr_i) flag_d = 1'b0;
        end
        always_ff @(posedge clk_i) begin
            if (!rst_ni) flag_q <= 1'b0;
            else         flag_q <= flag_d;
        end
        assign flags_o[g] = flag_q;
    end
endmodule

// File: rtl/sram_bus_monitor.sv
module sram_bus_monitor #(
    parameter int ADDR_W           = 16,
    parameter int DATA_W           = 16,
    parameter int CNT_W            = 16,
    parameter int SAMPLE_PERIOD_NS = 4,
    parameter int T_WP_NS          = 40,
    parameter int T_DW_NS          = 25,
    parameter int T_AW_NS          = 45,
    parameter int T_CW_NS          = 45,
    parameter int T_BW_NS          = 45,
    parameter int T_WC_NS          = 55
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  clear_i,
    input  logic                                  cs_n_i,
    input  logic                                  we_n_i,
    input  logic                                  oe_n_i,
    input  logic                                  lbe_n_i,
    input  logic                                  ube_n_i,
    input  logic [ADDR_W-1:0]                     addr_i,
    input  logic [DATA_W-1:0]                     data_i,
    input  logic                                  host_drive_i,
    output logic [sram_mon_pkg::NUM_RULES-1:0]    err_o,
    output logic [CNT_W-1:0]                      wr_count_o,
    output logic [CNT_W-1:0]                      rd_count_o
);
    import sram_mon_pkg::*;

    // Tick limits (R14)
    localparam int TK_WP = ns_to_ticks(T_WP_NS, SAMPLE_PERIOD_NS);
    localparam int TK_DW = ns_to_ticks(T_DW_NS, SAMPLE_PERIOD_NS);
    localparam int TK_AW = ns_to_ticks(T_AW_NS, SAMPLE_PERIOD_NS);
    localparam int TK_CW = ns_to_ticks(T_CW_NS, SAMPLE_PERIOD_NS);
    localparam int TK_BW = ns_to_ticks(T_BW_NS, SAMPLE_PERIOD_NS);
    localparam int TK_WC = ns_to_ticks(T_WC_NS, SAMPLE_PERIOD_NS);
    localparam int MAX_T = max2(max2(max2(TK_WP, TK_DW), max2(TK_AW, TK_CW)),
                                max2(TK_BW, TK_WC));
    localparam int TW    = $clog2(MAX_T + 1);

    localparam logic [TW-1:0]    WP_V  = TW'(TK_WP);
    localparam logic [TW-1:0]    DW_V  = TW'(TK_DW);
    localparam logic [TW-1:0]    AW_V  = TW'(TK_AW);
    localparam logic [TW-1:0]    CW_V  = TW'(TK_CW);
    localparam logic [TW-1:0]    BW_V  = TW'(TK_BW);
    localparam logic [TW-1:0]    WC_V  = TW'(TK_WC);
    localparam logic [TW-1:0]    SAT_V = TW'(MAX_T);
    localparam logic [TW-1:0]    T1_V  = TW'(1);
    localparam logic [CNT_W-1:0] C1_V  = CNT_W'(1);

    typedef struct packed {
        logic             primed;
        logic [TW-1:0]    cyc;
        logic             wrote;
        logic             win_bad;
        logic             rd_act;
        logic             rd_bad;
        logic             oe_n;
        logic [CNT_W-1:0] wr_cnt;
        logic [CNT_W-1:0] rd_cnt;
    } mon_t;

    mon_t st_d, st_q;

    logic first;
    assign first = !st_q.primed;

    // ---------------- run-length timers ----------------
    logic              win_now;
    logic              w_val, c_val, b_val;
    logic [TW-1:0]     w_cnt, c_cnt, b_cnt, a_cnt, d_cnt;
    logic              w_chg, c_chg, b_chg, a_chg, d_chg;
    logic [ADDR_W-1:0] a_val;
    logic [DATA_W-1:0] d_val;
    logic              be_off;

    assign win_now = !cs_n_i && !we_n_i;
    assign be_off  = lbe_n_i && ube_n_i;

    sram_mon_run_timer #(.W(1), .CNT_W(TW), .SAT(MAX_T)) u_win_tmr (
        .clk_i(clk_i), .rst_ni(rst_ni), .first_i(first), .value_i(win_now),
        .val_o(w_val), .cnt_o(w_cnt), .chg_o(w_chg));

    sram_mon_run_timer #(.W(1), .CNT_W(TW), .SAT(MAX_T)) u_cs_tmr (
        .clk_i(clk_i), .rst_ni(rst_ni), .first_i(first), .value_i(cs_n_i),
        .val_o(c_val), .cnt_o(c_cnt), .chg_o(c_chg));

    sram_mon_run_timer #(.W(1), .CNT_W(TW), .SAT(MAX_T)) u_be_tmr (
        .clk_i(clk_i), .rst_ni(rst_ni), .first_i(first), .value_i(be_off),
        .val_o(b_val), .cnt_o(b_cnt), .chg_o(b_chg));

    sram_mon_run_timer #(.W(ADDR_W), .CNT_W(TW), .SAT(MAX_T)) u_addr_tmr (
        .clk_i(clk_i), .rst_ni(rst_ni), .first_i(first), .value_i(addr_i),
        .val_o(a_val), .cnt_o(a_cnt), .chg_o(a_chg));

    sram_mon_run_timer #(.W(DATA_W), .CNT_W(TW), .SAT(MAX_T)) u_data_tmr (
        .clk_i(clk_i), .rst_ni(rst_ni), .first_i(first), .value_i(data_i),
        .val_o(d_val), .cnt_o(d_cnt), .chg_o(d_chg));

    // ---------------- rule evaluation ----------------
    logic                 close_evt, move_evt, oe_rise, read_state;
    logic                 close_fail;
    logic [NUM_RULES-1:0] rule_hit;

    // Window closes on the first sample where the overlap is gone.
    assign close_evt  = w_chg && w_val;
    assign move_evt   = !first && w_val && win_now && a_chg;
    assign oe_rise    = !first && !st_q.oe_n && oe_n_i;
    assign read_state = !cs_n_i && !oe_n_i && we_n_i && !be_off;

    always_comb begin
        rule_hit = '0;
        // Registered run lengths describe the last open sample, so a change
        // on the closing sample itself (zero hold) is never counted against it.
        rule_hit[RULE_PULSE]  = close_evt && (w_cnt < WP_V);
        rule_hit[RULE_DSETUP] = close_evt && (d_cnt < DW_V);
        rule_hit[RULE_ASETUP] = close_evt && (a_cnt < AW_V);
        rule_hit[RULE_CSETUP] = close_evt && (c_val || (c_cnt < CW_V));
        rule_hit[RULE_BSETUP] = close_evt && (b_val || (b_cnt < BW_V));
        rule_hit[RULE_CYCLE]  = a_chg && (st_q.wrote || close_evt) && (st_q.cyc < WC_V);
        rule_hit[RULE_MOVE]   = move_evt;
        rule_hit[RULE_CONT]   = host_drive_i && !cs_n_i && !oe_n_i && we_n_i;
    end

    assign close_fail = |rule_hit[RULE_BSETUP:RULE_PULSE];

    always_comb begin
        st_d        = st_q;
        st_d.primed = 1'b1;
        st_d.oe_n   = oe_n_i;

        // Address period length and write presence
        if (first) begin
            st_d.cyc   = SAT_V;
            st_d.wrote = 1'b0;
        end else if (a_chg) begin
            st_d.cyc   = T1_V;
            st_d.wrote = 1'b0;
        end else begin
            if (st_q.cyc < SAT_V) st_d.cyc = st_q.cyc + T1_V;
            st_d.wrote = st_q.wrote || close_evt;
        end

        // Address movement inside the open window
        if (win_now && w_val && !first) st_d.win_bad = st_q.win_bad || move_evt;
        else                            st_d.win_bad = 1'b0;

        if (close_evt && !close_fail && !st_q.win_bad)
            st_d.wr_cnt = st_q.wr_cnt + C1_V;

        // Read tracking between output-enable rises
        if (oe_rise) begin
            if (st_q.rd_act && !st_q.rd_bad) st_d.rd_cnt = st_q.rd_cnt + C1_V;
            st_d.rd_act = 1'b0;
            st_d.rd_bad = 1'b0;
        end else begin
            st_d.rd_act = st_q.rd_act || read_state;
            st_d.rd_bad = st_q.rd_bad || rule_hit[RULE_CONT];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.oe_n <= 1'b1;
        end else begin
            st_q      <= st_d;
        end
    end

    sram_mon_sticky #(.N(NUM_RULES)) u_flags (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i),
        .set_i(rule_hit), .flags_o(err_o));

    assign wr_count_o = st_q.wr_cnt;
    assign rd_count_o = st_q.rd_cnt;

endmodule

// File: rtl/sram_bus_monitor_chk.sv
module sram_bus_monitor_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic                                clk_i,
    input logic                                rst_ni,
    input logic                                clear_i,
    input logic                                cs_n_i,
    input logic                                we_n_i,
    input logic                                oe_n_i,
    input logic                                host_drive_i,
    input logic [ADDR_W-1:0]                   addr_i,
    input logic [sram_mon_pkg::NUM_RULES-1:0]  err_o,
    input logic [CNT_W-1:0]                    wr_count_o,
    input logic [CNT_W-1:0]                    rd_count_o
);
    import sram_mon_pkg::*;

    logic seen_q;
    logic win_now;
    assign win_now = !cs_n_i && !we_n_i;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
    end

    a_r11_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(clear_i) |-> (($past(err_o) & ~err_o) == '0));

    a_r11_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clear_i) |-> (err_o == '0));

    a_r10_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_drive_i && !cs_n_i && !oe_n_i && we_n_i && !clear_i) |=> err_o[RULE_CONT]);

    a_r9_addr_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && win_now && $past(win_now) && (addr_i != $past(addr_i)) && !clear_i)
        |=> err_o[RULE_MOVE]);

    a_r12_wr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_count_o == $past(wr_count_o)) || (wr_count_o == CNT_W'($past(wr_count_o) + 1'b1)));

    a_r12_wr_at_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_count_o != $past(wr_count_o)) |-> ($past(cs_n_i || we_n_i) && $past(win_now, 2)));

    a_r13_rd_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_count_o != $past(rd_count_o)) |-> ($past(oe_n_i) && !$past(oe_n_i, 2)));

endmodule

bind sram_bus_monitor sram_bus_monitor_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sram_bus_monitor_bench.sv
`timescale 1ns/1ps
module sram_bus_monitor_bench;

    localparam logic [7:0] E_P = 8'h01, E_D = 8'h02, E_A = 8'h04, E_C = 8'h08;
    localparam logic [7:0] E_B = 8'h10, E_Y = 8'h20, E_M = 8'h40, E_X = 8'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lbe_n = 1'b1, ube_n = 1'b1;
    logic [15:0] addr = 16'h0000, data = 16'h0000;
    logic        host = 1'b0;
    logic [7:0]  err;
    logic [15:0] wr_cnt, rd_cnt;

    int checks = 0;
    int fails  = 0;
    int exp_wr = 0;
    int exp_rd = 0;

    always #2 clk = ~clk;

    sram_bus_monitor u_sram_bus_monitor (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
        .cs_n_i(cs_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .lbe_n_i(lbe_n), .ube_n_i(ube_n),
        .addr_i(addr), .data_i(data), .host_drive_i(host),
        .err_o(err), .wr_count_o(wr_cnt), .rd_count_o(rd_cnt));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lbe_n = 1'b1; ube_n = 1'b1;
        host = 1'b0; clear = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic clr();
        clear = 1'b1;
        tick();
        clear = 1'b0;
    endtask

    task automatic new_addr(input logic [15:0] a);
        addr = a;
        tick();
    endtask

    // One write: per-signal start index, close at index e, then tail samples.
    task automatic wr(input logic [15:0] a, input logic [15:0] d,
                      input int s_cs, input int s_be, input int s_ad, input int s_dt,
                      input int s_we, input int e, input int tail);
        for (int i = 0; i <= e + tail; i++) begin
            if (i < e) begin
                cs_n  = (i >= s_cs) ? 1'b0 : 1'b1;
                lbe_n = (i >= s_be) ? 1'b0 : 1'b1;
                ube_n = (i >= s_be) ? 1'b0 : 1'b1;
                we_n  = (i >= s_we) ? 1'b0 : 1'b1;
                addr  = (i >= s_ad) ? a : ~a;
                data  = (i >= s_dt) ? d : ~d;
            end else begin
                cs_n = 1'b1; we_n = 1'b1; lbe_n = 1'b1; ube_n = 1'b1;
                addr = a; data = d;
            end
            oe_n = 1'b1; host = 1'b0;
            tick();
        end
    endtask

    task automatic t_reset();
        chk("R1 err after reset", 32'(err), 32'h0);
        chk("R1 wr_count after reset", 32'(wr_cnt), 32'h0);
        chk("R1 rd_count after reset", 32'(rd_cnt), 32'h0);
    endtask

    task automatic t_legal();
        wr(16'h1111, 16'hA5A5, 0, 0, 0, 0, 2, 12, 1);
        exp_wr++;
        chk("R12 R3 R14 legal write counted (pulse 10)", 32'(wr_cnt), 32'(exp_wr));
        new_addr(16'h2000);
        chk("R8 cycle of 14 samples legal", 32'(err), 32'h0);
        idle(2);
    endtask

    task automatic t_pulse();
        wr(16'h1200, 16'h0F0F, 0, 0, 0, 0, 3, 12, 1);
        chk("R3 R14 pulse of 9 flagged", 32'(err), 32'(E_P));
        chk("R12 short pulse not counted", 32'(wr_cnt), 32'(exp_wr));
        new_addr(16'h2100); clr();
        chk("R11 clear empties flags", 32'(err), 32'h0);
    endtask

    task automatic t_window();
        wr(16'h1300, 16'h1234, 2, 0, 0, 0, 0, 12, 1);
        chk("R2 overlap from later strobe: only chip-select setup", 32'(err), 32'(E_C));
        new_addr(16'h2200); clr();
        wr(16'h1310, 16'h4321, 12, 0, 0, 0, 2, 12, 1);
        chk("R2 write strobe without chip select: no rule", 32'(err), 32'h0);
        chk("R2 write strobe without chip select: no count", 32'(wr_cnt), 32'(exp_wr));
        new_addr(16'h2210);
    endtask

    task automatic t_data();
        wr(16'h1400, 16'h5555, 0, 0, 0, 6, 2, 12, 1);
        chk("R4 R14 data setup 6 flagged", 32'(err), 32'(E_D));
        new_addr(16'h2300); clr();
        wr(16'h1410, 16'h6666, 0, 0, 0, 5, 2, 12, 1);
        exp_wr++;
        chk("R4 data setup 7 legal", 32'(err), 32'h0);
        chk("R4 data setup 7 counted", 32'(wr_cnt), 32'(exp_wr));
        new_addr(16'h2310);
    endtask

    task automatic t_setups();
        wr(16'h1500, 16'h7777, 0, 0, 1, 0, 2, 12, 2);
        chk("R5 address setup 11 flagged", 32'(err), 32'(E_A));
        new_addr(16'h2400); clr();
        wr(16'h1510, 16'h8888, 1, 0, 0, 0, 2, 12, 1);
        chk("R6 chip-select setup 11 flagged", 32'(err), 32'(E_C));
        new_addr(16'h2410); clr();
        wr(16'h1520, 16'h9999, 0, 1, 0, 0, 2, 12, 1);
        chk("R7 byte-enable setup 11 flagged", 32'(err), 32'(E_B));
        chk("R12 failed setups not counted", 32'(wr_cnt), 32'(exp_wr));
        new_addr(16'h2420); clr();
    endtask

    task automatic t_cycle();
        wr(16'h1600, 16'hAAAA, 0, 0, 0, 0, 2, 12, 0);
        exp_wr++;
        chk("R12 write counted before cycle check", 32'(wr_cnt), 32'(exp_wr));
        chk("R8 no flag before address moves", 32'(err), 32'h0);
        new_addr(16'h2500);
        chk("R8 cycle of 13 flagged", 32'(err), 32'(E_Y));
        clr();
    endtask

    task automatic t_move();
        wr(16'h1700, 16'hBBBB, 0, 0, 5, 0, 2, 12, 6);
        chk("R9 address move inside window flagged", 32'(err), 32'(E_M | E_A));
        chk("R12 moved write not counted", 32'(wr_cnt), 32'(exp_wr));
        idle(5);
        chk("R11 flags stay set when idle", 32'(err), 32'(E_M | E_A));
        new_addr(16'h2600); clr();
    endtask

    task automatic t_contention();
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; lbe_n = 1'b0; ube_n = 1'b0; host = 1'b1;
        tick();
        chk("R10 contention flagged", 32'(err), 32'(E_X));
        host = 1'b0; oe_n = 1'b1;
        tick();
        chk("R13 contended read not counted", 32'(rd_cnt), 32'(exp_rd));
        idle(1);
        oe_n = 1'b0; cs_n = 1'b0; lbe_n = 1'b0; host = 1'b1; clear = 1'b1;
        tick();
        chk("R11 clear wins over contention", 32'(err), 32'h0);
        clear = 1'b0;
        tick();
        chk("R10 contention again after clear", 32'(err), 32'(E_X));
        idle(1);
        clr();
    endtask

    task automatic t_read();
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; lbe_n = 1'b0; ube_n = 1'b1; host = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        chk("R13 no count while output enable low", 32'(rd_cnt), 32'(exp_rd));
        oe_n = 1'b1;
        tick();
        exp_rd++;
        chk("R13 legal read counted at rise", 32'(rd_cnt), 32'(exp_rd));
        idle(1);
        cs_n = 1'b0; oe_n = 1'b0; lbe_n = 1'b1; ube_n = 1'b1;
        tick(); tick();
        oe_n = 1'b1;
        tick();
        chk("R13 read with no byte enable not counted", 32'(rd_cnt), 32'(exp_rd));
        chk("R10 read without drive raises nothing", 32'(err), 32'h0);
        idle(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        idle(3);
        t_legal();
        t_pulse();
        t_window();
        t_data();
        t_setups();
        t_cycle();
        t_move();
        t_contention();
        t_read();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule